// File: doc/BRIEF.md
# Dual-Port Video Memory Row Transfer Controller

This block holds the row-transfer side of a dual-port video memory. A small array is organised as rows of columns, and each column holds one bit per I/O block. A serial register holds one full row and is walked by a serial pointer that advances on the serial clock. The block samples the memory's control strobes in the system clock domain and finds their edges there. When the row strobe falls, it reads the levels of the other strobes to decide which kind of transfer the cycle is: a read transfer (array row into the serial register), a write transfer (serial register into an array row, under a per-block mask) or a pseudo-write (only the serial port direction changes).

A read transfer takes effect only when the transfer/output-enable strobe rises. Until then, a serial port in output mode keeps streaming the old row, so one row follows another with no gap. Write and pseudo-write transfers take effect when the row strobe rises. Serial clock edges that arrive where they are not allowed are refused and reported on a one-cycle error flag.

Top module: `vmx_transfer_ctrl`

## Requirements
- R1: When the row strobe falls while the column strobe is high, the transfer strobe is low, the write-mask strobe is high and the function select is low, a read transfer starts. When the transfer strobe next rises, the addressed row is copied into the serial register and the serial port enters output mode (`sport_in`=0).
- R2: When the row strobe falls while the column strobe is high, the transfer strobe is low, the write-mask strobe is low, the serial enable is low and the function select is low, a write transfer starts. When the row strobe rises, each I/O block b whose bit b of `dq_mask` was 1 at the falling edge receives the serial register's bits for that block. Blocks whose mask bit was 0 keep their old contents. The port then enters input mode (`sport_in`=1).
- R3: The same strobe levels as R2 but with the serial enable high start a pseudo-write. It changes no array contents and only puts the port in input mode.
- R4: The row comes from `addr` at the row-strobe falling edge. The column on `addr` at the column-strobe falling edge within the same transfer becomes the pointer start when the transfer completes (0 if the column strobe did not fall).
- R5: During a read transfer in output mode, each serial rising edge before the transfer strobe rises still presents the previous row's bits. The first edge after the transfer presents the new row at the start column.
- R6: In input mode, each serial rising edge stores `sdin` at the pointer and advances the pointer.
- R7: In output mode, each serial rising edge drives the pointed column onto `sdout`. In both modes the pointer advances by one on each accepted edge and wraps from COLS-1 to 0.
- R8: A serial rising edge inside a write or pseudo-write cycle (row strobe fallen, not yet risen) leaves the serial register and pointer unchanged and pulses `proto_err` for one cycle.
- R9: A serial rising edge in output mode with `sdin_drive` high changes no state and pulses `proto_err`.
- R10: A serial rising edge inside a read-transfer window while the port is in input mode changes no state and pulses `proto_err`.
- R11: After reset, `sdout`=0, `sport_in`=1, `proto_err`=0 and the pointer is 0.
- R12: A row-strobe falling edge with the function select high, or with the column strobe already low, starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| xfer_oe_n | input | 1 | Transfer / output-enable strobe |
| wmask_en_n | input | 1 | Write-mask / write-enable strobe |
| ser_en_n | input | 1 | Serial enable, separates write from pseudo-write |
| func_sel | input | 1 | Special-function select; must be low for a transfer |
| addr | input | AW | Row or column address |
| dq_mask | input | BLOCKS | Per-block write mask, read at row-strobe fall |
| sclk | input | 1 | Serial clock, sampled |
| sdin | input | BLOCKS | Serial input data |
| sdin_drive | input | 1 | High when an outside writer drives the serial lines |
| sdout | output | BLOCKS | Serial output data |
| sport_in | output | 1 | 1 = serial port in input mode |
| proto_err | output | 1 | One-cycle protocol-error pulse |

## Verification
The hardest case to reach is the real-time read. The port must already be in output mode with a known row partly streamed out, and serial edges must land after a second read transfer has been decoded but before its transfer strobe rises. The stimulus gets there in steps. It loads two rows through the serial input, commits them with write transfers (one partial under a mask), and reads one row out past the wrap. It then opens a second read transfer and pulses the serial clock inside that window before and after the commit, while a behavioural reference model predicts every output on every clock.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

  // Transfer kind decoded at the row-strobe falling edge
  typedef enum logic [1:0] {
    XK_NONE   = 2'd0,
    XK_READ   = 2'd1,
    XK_WRITE  = 2'd2,
    XK_PSEUDO = 2'd3
  } xkind_e;

  // Transfer window currently open
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

endpackage

// File: rtl/vmx_strobe_dec.sv
module vmx_strobe_dec
  import vmx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   row_strobe_n,
  input  logic   col_strobe_n,
  input  logic   xfer_oe_n,
  input  logic   wmask_en_n,
  input  logic   ser_en_n,
  input  logic   func_sel,
  input  logic   sclk,
  output logic   row_fall,
  output logic   row_rise,
  output logic   col_fall,
  output logic   oe_rise,
  output logic   sc_rise,
  output xkind_e kind
);

  logic row_p, col_p, oe_p, sc_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_p <= 1'b1;
      col_p <= 1'b1;
      oe_p  <= 1'b1;
      sc_p  <= 1'b0;
    end else begin
      row_p <= row_strobe_n;
      col_p <= col_strobe_n;
      oe_p  <= xfer_oe_n;
      sc_p  <= sclk;
    end
  end

  assign row_fall = row_p & ~row_strobe_n;
  assign row_rise = ~row_p & row_strobe_n;
  assign col_fall = col_p & ~col_strobe_n;
  assign oe_rise  = ~oe_p & xfer_oe_n;
  assign sc_rise  = ~sc_p & sclk;

  // Level decode, meaningful only together with row_fall
  always_comb begin
    kind = XK_NONE;
    if (col_strobe_n && !xfer_oe_n && !func_sel) begin
      if (wmask_en_n)    kind = XK_READ;
      else if (ser_en_n) kind = XK_PSEUDO;
      else               kind = XK_WRITE;
    end
  end

endmodule

// File: rtl/vmx_xfer_fsm.sv
module vmx_xfer_fsm
  import vmx_pkg::*;
#(
  parameter int RAW    = 4,
  parameter int CAW    = 5,
  parameter int BLOCKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_fall,
  input  logic              row_rise,
  input  logic              col_fall,
  input  logic              oe_rise,
  input  xkind_e            kind,
  input  logic [RAW-1:0]    row_addr,
  input  logic [CAW-1:0]    col_addr,
  input  logic [BLOCKS-1:0] mask_in,
  output logic              in_read,
  output logic              in_write,
  output logic              rd_commit,
  output logic              wr_commit,
  output logic              ram_we,
  output logic [RAW-1:0]    row_q,
  output logic [CAW-1:0]    col_q,
  output logic [BLOCKS-1:0] mask_q
);

  phase_e            st_q, st_d;
  logic [RAW-1:0]    row_d;
  logic [CAW-1:0]    col_d;
  logic [BLOCKS-1:0] mask_d;
  logic              pseudo_q, pseudo_d;
  logic              cap_en;

  // next-state
  always_comb begin
    st_d     = st_q;
    row_d    = row_q;
    col_d    = col_q;
    mask_d   = mask_q;
    pseudo_d = pseudo_q;
    cap_en   = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (row_fall && kind != XK_NONE) begin
          cap_en   = 1'b1;
          st_d     = (kind == XK_READ) ? PH_READ : PH_WRITE;
          row_d    = row_addr;
          mask_d   = mask_in;
          pseudo_d = (kind == XK_PSEUDO);
          col_d    = '0;
        end
      end
      PH_READ: begin
        if (col_fall) begin
          cap_en = 1'b1;
          col_d  = col_addr;
        end
        if (oe_rise) st_d = PH_IDLE;
      end
      PH_WRITE: begin
        if (col_fall) begin
          cap_en = 1'b1;
          col_d  = col_addr;
        end
        if (row_rise) st_d = PH_IDLE;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      mask_q   <= '0;
      pseudo_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        row_q    <= row_d;
        col_q    <= col_d;
        mask_q   <= mask_d;
        pseudo_q <= pseudo_d;
      end
    end
  end

  assign in_read   = (st_q == PH_READ);
  assign in_write  = (st_q == PH_WRITE);
  assign rd_commit = in_read & oe_rise;
  assign wr_commit = in_write & row_rise;
  assign ram_we    = wr_commit & ~pseudo_q;

  // R12: a rejected strobe pattern leaves the block idle
  p_no_start_on_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && row_fall && kind == XK_NONE) |=> (st_q == PH_IDLE));

  // R4: column latched at the column-strobe fall inside a window
  p_col_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != PH_IDLE) && col_fall) |=> (col_q == $past(col_addr)));

endmodule

// File: rtl/vmx_row_ram.sv
module vmx_row_ram #(
  parameter int ROWS   = 16,
  parameter int COLS   = 32,
  parameter int BLOCKS = 4,
  localparam int RAW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [RAW-1:0]               wrow,
  input  logic [BLOCKS-1:0]            wmask,
  input  logic [COLS-1:0][BLOCKS-1:0]  wdata,
  input  logic [RAW-1:0]               rrow,
  output logic [COLS-1:0][BLOCKS-1:0]  rdata
);

  logic [COLS-1:0][BLOCKS-1:0] mem_q [ROWS];

  // storage array: no reset, write enable explicit
  always_ff @(posedge clk) begin
    if (we) begin
      for (int c = 0; c < COLS; c++) begin
        for (int b = 0; b < BLOCKS; b++) begin
          if (wmask[b]) mem_q[wrow][c][b] <= wdata[c][b];
        end
      end
    end
  end

  assign rdata = mem_q[rrow];

endmodule

// File: rtl/vmx_sam_port.sv
module vmx_sam_port #(
  parameter int COLS   = 32,
  parameter int BLOCKS = 4,
  localparam int CAW   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sc_rise,
  input  logic                         rd_commit,
  input  logic                         wr_commit,
  input  logic                         in_read,
  input  logic                         in_write,
  input  logic [CAW-1:0]               start_col,
  input  logic [COLS-1:0][BLOCKS-1:0]  load_row,
  input  logic [BLOCKS-1:0]            sdin,
  input  logic                         sdin_drive,
  output logic [COLS-1:0][BLOCKS-1:0]  sam_q,
  output logic [BLOCKS-1:0]            sdout,
  output logic                         sport_in,
  output logic                         proto_err
);

  logic [COLS-1:0][BLOCKS-1:0] sam_d;
  logic                        sam_ld;
  logic [CAW-1:0]              ptr_q, ptr_d, ptr_inc;
  logic                        in_q, in_d;
  logic [BLOCKS-1:0]           dout_q, dout_d;
  logic                        err_q, err_d;
  logic                        forbid;

  assign forbid  = in_write | (in_read & in_q);
  assign ptr_inc = (ptr_q == CAW'(COLS - 1)) ? '0 : ptr_q + 1'b1;

  // next-state
  always_comb begin
    sam_d  = sam_q;
    sam_ld = 1'b0;
    ptr_d  = ptr_q;
    in_d   = in_q;
    dout_d = dout_q;
    err_d  = sc_rise & (forbid | (~in_q & sdin_drive));
    if (rd_commit) begin
      sam_d  = load_row;
      sam_ld = 1'b1;
      ptr_d  = start_col;
      in_d   = 1'b0;
    end else if (wr_commit) begin
      ptr_d  = start_col;
      in_d   = 1'b1;
    end else if (sc_rise && !forbid) begin
      if (in_q) begin
        sam_d[ptr_q] = sdin;
        sam_ld       = 1'b1;
        ptr_d        = ptr_inc;
      end else if (!sdin_drive) begin
        dout_d = sam_q[ptr_q];
        ptr_d  = ptr_inc;
      end
    end
  end

  // serial register: data only, no reset
  always_ff @(posedge clk) begin
    if (sam_ld) sam_q <= sam_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      in_q   <= 1'b1;
      dout_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      in_q   <= in_d;
      dout_q <= dout_d;
      err_q  <= err_d;
    end
  end

  assign sdout     = dout_q;
  assign sport_in  = in_q;
  assign proto_err = err_q;

  p_rd_enters_output_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_commit |=> !sport_in);

  p_wr_enters_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> sport_in);

  p_ptr_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit || wr_commit) |=> (ptr_q == $past(start_col)));

  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_rise && !forbid && !rd_commit && !wr_commit && (in_q || !sdin_drive)
     && ptr_q == CAW'(COLS - 1)) |=> (ptr_q == '0));

  p_sam_frozen_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |=> $stable(sam_q));

  p_err_needs_sc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(sc_rise));

endmodule

// File: rtl/vmx_transfer_ctrl.sv
module vmx_transfer_ctrl
  import vmx_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 32,
  parameter int BLOCKS = 4,
  localparam int RAW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW    = (RAW > CAW) ? RAW : CAW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              xfer_oe_n,
  input  logic              wmask_en_n,
  input  logic              ser_en_n,
  input  logic              func_sel,
  input  logic [AW-1:0]     addr,
  input  logic [BLOCKS-1:0] dq_mask,
  input  logic              sclk,
  input  logic [BLOCKS-1:0] sdin,
  input  logic              sdin_drive,
  output logic [BLOCKS-1:0] sdout,
  output logic              sport_in,
  output logic              proto_err
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic row_fall, row_rise, col_fall, oe_rise, sc_rise;
  xkind_e kind;

  vmx_strobe_dec u_dec (
    .clk          (clk),
    .rst_n        (rst_q),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .xfer_oe_n    (xfer_oe_n),
    .wmask_en_n   (wmask_en_n),
    .ser_en_n     (ser_en_n),
    .func_sel     (func_sel),
    .sclk         (sclk),
    .row_fall     (row_fall),
    .row_rise     (row_rise),
    .col_fall     (col_fall),
    .oe_rise      (oe_rise),
    .sc_rise      (sc_rise),
    .kind         (kind)
  );

  logic              in_read, in_write, rd_commit, wr_commit, ram_we;
  logic [RAW-1:0]    row_q;
  logic [CAW-1:0]    col_q;
  logic [BLOCKS-1:0] mask_q;

  vmx_xfer_fsm #(.RAW(RAW), .CAW(CAW), .BLOCKS(BLOCKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_q),
    .row_fall  (row_fall),
    .row_rise  (row_rise),
    .col_fall  (col_fall),
    .oe_rise   (oe_rise),
    .kind      (kind),
    .row_addr  (addr[RAW-1:0]),
    .col_addr  (addr[CAW-1:0]),
    .mask_in   (dq_mask),
    .in_read   (in_read),
    .in_write  (in_write),
    .rd_commit (rd_commit),
    .wr_commit (wr_commit),
    .ram_we    (ram_we),
    .row_q     (row_q),
    .col_q     (col_q),
    .mask_q    (mask_q)
  );

  logic [COLS-1:0][BLOCKS-1:0] sam_row, ram_row;

  vmx_row_ram #(.ROWS(ROWS), .COLS(COLS), .BLOCKS(BLOCKS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .wrow  (row_q),
    .wmask (mask_q),
    .wdata (sam_row),
    .rrow  (row_q),
    .rdata (ram_row)
  );

  vmx_sam_port #(.COLS(COLS), .BLOCKS(BLOCKS)) u_sam (
    .clk        (clk),
    .rst_n      (rst_q),
    .sc_rise    (sc_rise),
    .rd_commit  (rd_commit),
    .wr_commit  (wr_commit),
    .in_read    (in_read),
    .in_write   (in_write),
    .start_col  (col_q),
    .load_row   (ram_row),
    .sdin       (sdin),
    .sdin_drive (sdin_drive),
    .sam_q      (sam_row),
    .sdout      (sdout),
    .sport_in   (sport_in),
    .proto_err  (proto_err)
  );

endmodule

// File: tb/sim_vmx_transfer_ctrl.sv
module sim_vmx_transfer_ctrl;

  localparam int R  = 16;
  localparam int C  = 32;
  localparam int B  = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst_n;
  logic          ras_n, cas_n, oe_n, wm_n, se_n, fs;
  logic [AW-1:0] addr;
  logic [B-1:0]  mask, sdin, sdout;
  logic          sclk, drive, sport_in, proto_err;

  vmx_transfer_ctrl #(.ROWS(R), .COLS(C), .BLOCKS(B)) u0 (
    .clk(clk), .rst_n(rst_n), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
    .xfer_oe_n(oe_n), .wmask_en_n(wm_n), .ser_en_n(se_n), .func_sel(fs),
    .addr(addr), .dq_mask(mask), .sclk(sclk), .sdin(sdin),
    .sdin_drive(drive), .sdout(sdout), .sport_in(sport_in),
    .proto_err(proto_err)
  );

  int    vectors = 0;
  int    fails   = 0;
  int    wd      = 0;
  bit    done    = 0;
  string cur     = "R11";

  // ---------------- behavioural reference ----------------
  logic [B-1:0] m_ram [R][C];
  logic [B-1:0] m_sam [C];
  int           m_ptr, m_ph, m_row, m_col;
  logic [B-1:0] m_mask, m_sout;
  bit           m_in, m_err, m_pseudo;
  bit           p_ras, p_cas, p_oe, p_sc, rs1, rs2;

  always @(posedge clk) begin
    if (!rs2) begin
      p_ras = 1; p_cas = 1; p_oe = 1; p_sc = 0;
      m_ptr = 0; m_in = 1; m_sout = '0; m_err = 0;
      m_ph = 0; m_row = 0; m_col = 0; m_mask = '0; m_pseudo = 0;
    end else begin
      bit rf, rr, cf, orr, sr, forbid, rdc, wrc;
      rf  = p_ras && !ras_n;  rr = !p_ras && ras_n;
      cf  = p_cas && !cas_n;  orr = !p_oe && oe_n;
      sr  = !p_sc && sclk;
      rdc = (m_ph == 1) && orr;
      wrc = (m_ph == 2) && rr;
      forbid = (m_ph == 2) || (m_ph == 1 && m_in);
      m_err = sr && (forbid || (!m_in && drive));
      if (rdc) begin
        for (int c = 0; c < C; c++) m_sam[c] = m_ram[m_row][c];
        m_ptr = m_col; m_in = 0;
      end else if (wrc) begin
        if (!m_pseudo)
          for (int c = 0; c < C; c++)
            for (int b = 0; b < B; b++)
              if (m_mask[b]) m_ram[m_row][c][b] = m_sam[c][b];
        m_ptr = m_col; m_in = 1;
      end else if (sr && !forbid) begin
        if (m_in) begin
          m_sam[m_ptr] = sdin; m_ptr = (m_ptr + 1) % C;
        end else if (!drive) begin
          m_sout = m_sam[m_ptr]; m_ptr = (m_ptr + 1) % C;
        end
      end
      case (m_ph)
        0: if (rf && cas_n && !oe_n && !fs) begin
             m_ph = wm_n ? 1 : 2;
             m_pseudo = !wm_n && se_n;
             m_row = int'(addr) % R; m_mask = mask; m_col = 0;
           end
        1: begin if (cf) m_col = int'(addr) % C; if (orr) m_ph = 0; end
        default: begin if (cf) m_col = int'(addr) % C; if (rr) m_ph = 0; end
      endcase
      p_ras = ras_n; p_cas = cas_n; p_oe = oe_n; p_sc = sclk;
    end
    if (!rst_n) begin rs1 = 0; rs2 = 0; end
    else begin rs2 = rs1; rs1 = 1; end
  end

  // ---------------- comparison every cycle ----------------
  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur, "sdout", int'(sdout), int'(m_sout));
      chk(cur, "sport_in", int'(sport_in), int'(m_in));
      chk(cur, "proto_err", int'(proto_err), int'(m_err));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL all: watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic sc_pulse(logic [B-1:0] d, logic drv);
    @(negedge clk); sdin = d; drive = drv; sclk = 1;
    @(negedge clk); sclk = 0;
  endtask

  task automatic begin_xfer(logic c, logic o, logic w, logic s, logic f,
                            int row, logic [B-1:0] m);
    @(negedge clk);
    cas_n = c; oe_n = o; wm_n = w; se_n = s; fs = f;
    addr = AW'(row); mask = m;
    @(negedge clk); ras_n = 0;
    @(negedge clk);
  endtask

  task automatic col_strobe(int col);
    @(negedge clk); addr = AW'(col); cas_n = 0;
    @(negedge clk);
  endtask

  task automatic end_read;
    @(negedge clk); oe_n = 1;
    @(negedge clk); ras_n = 1; cas_n = 1; fs = 0;
    @(negedge clk);
  endtask

  task automatic end_write;
    @(negedge clk); ras_n = 1;
    @(negedge clk); cas_n = 1; oe_n = 1; fs = 0;
    @(negedge clk);
  endtask

  task automatic burst(int n, int seed);
    for (int i = 0; i < n; i++) sc_pulse(B'(i * seed + 3), 1'b0);
  endtask

  initial begin
    rst_n = 0; ras_n = 1; cas_n = 1; oe_n = 1; wm_n = 1; se_n = 1; fs = 0;
    addr = '0; mask = '0; sclk = 0; sdin = '0; drive = 0;
    repeat (3) @(negedge clk);
    // R11: reset values seen at the ports
    chk("R11", "reset sdout", int'(sdout), 0);
    chk("R11", "reset sport_in", int'(sport_in), 1);
    chk("R11", "reset proto_err", int'(proto_err), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur = "R6/R7";           // fill in input mode, one pulse past the wrap
    for (int i = 0; i <= C; i++) sc_pulse(B'(i * 5 + 1), 1'b0);

    cur = "R2/R4";           // full write into row 3, pointer start 5
    begin_xfer(1, 0, 0, 0, 0, 3, 4'hF);
    col_strobe(5);
    cur = "R8";              // serial edge inside the write window
    sc_pulse(4'h9, 1'b0);
    end_write;

    cur = "R6";
    burst(C, 3);
    cur = "R2";              // full write row 7, then masked overwrite
    begin_xfer(1, 0, 0, 0, 0, 7, 4'hF);
    col_strobe(0);
    end_write;
    burst(C, 7);
    begin_xfer(1, 0, 0, 0, 0, 7, 4'b0101);
    col_strobe(2);
    end_write;

    cur = "R1/R4/R7";        // read row 7 from column 4, past the wrap
    begin_xfer(1, 0, 1, 1, 0, 7, 4'h0);
    col_strobe(4);
    end_read;
    burst(C + 8, 1);

    cur = "R9";
    sc_pulse(4'hA, 1'b1);
    sc_pulse(4'h5, 1'b1);
    sc_pulse(4'h0, 1'b0);

    cur = "R5";              // real-time read: old row streams until commit
    begin_xfer(1, 0, 1, 1, 0, 3, 4'h0);
    col_strobe(10);
    burst(3, 1);
    end_read;
    burst(6, 1);

    cur = "R3";              // pseudo-write, then prove row 7 untouched
    begin_xfer(1, 0, 0, 1, 0, 7, 4'hF);
    col_strobe(1);
    end_write;
    burst(4, 11);
    begin_xfer(1, 0, 1, 1, 0, 7, 4'h0);
    col_strobe(0);
    end_read;
    burst(C, 1);

    cur = "R10";             // input mode, serial edge in a read window
    begin_xfer(1, 0, 0, 1, 0, 0, 4'hF);
    end_write;
    begin_xfer(1, 0, 1, 1, 0, 3, 4'h0);
    col_strobe(0);
    sc_pulse(4'h6, 1'b0);
    end_read;
    burst(5, 1);

    cur = "R12";             // function select high, then column strobe low
    begin_xfer(1, 0, 1, 1, 1, 7, 4'h0);
    col_strobe(9);
    end_read;
    burst(4, 1);
    begin_xfer(0, 0, 0, 0, 0, 3, 4'hF);
    end_write;
    burst(4, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule